// File: doc/BRIEF.md
# I2C master register controller

This block is the software-facing half of an I2C master. It has five byte-wide registers in a 0x14-byte window: control, status, slave address, data shift and line control. The CPU writes and reads them to run a transfer. The block does no bit timing on the wires. It turns register accesses into byte-level operations on a downstream request/acknowledge channel: start (with a 7-bit address and a direction bit), write a byte, read a byte, and stop. A separate bit engine carries these operations out and reports a received byte and an acknowledge flag.

A transfer moves forward only when software touches a register. The accesses that move it are:
- setting or clearing the start bit in status,
- clearing the sticky interrupt-pending flag in control,
- writing the data register during transmit,
- reading the data register during receive.

When an operation finishes, the block updates its registers and raises the pending flag and the level interrupt, if interrupts are enabled. The address and line-control registers are plain storage. Slave-mode transfers, bit timing, prescaling and line filtering are not part of this block.

Top module: `i2c_host_regs`

## Requirements
- R1: After a synchronous active-low reset, all five registers read 0x00, `irq` is low and `op_req` is low.
- R2: The register offsets are fixed:
  - control at 0x00
  - status at 0x04
  - address at 0x08
  - data at 0x0C
  - line control at 0x10

  Address and line control read back what was written to them. A read of any other offset returns 0x00, and a write to any other offset changes nothing.
- R3: A control write stores every bit except bit 4 (interrupt pending), which a write can only clear and never set.
- R4: A status write keeps the busy bit (bit 5) and takes every other bit from the written value. If the written bit 4 (output enable) is 0, the write also clears busy, drops `irq` and issues no operation.
- R5: A status write in a master mode (bit 7 = 1) with bits 5 and 4 set does three things:
  - clears status bit 0,
  - sets busy,
  - issues a start with address = data[7:1] and direction = data[0].

  The operation codes on `op_code` are start = 0, write = 1, read = 2 and stop = 3.
- R6: A start can be refused (`op_nack` = 1) while acknowledge generation (control bit 7) is set. Then status bit 0 is set and no byte is received. Otherwise, in receive mode (status[7:6] = 2), a read follows at once and its byte is loaded into data.
- R7: Each completed start, write or read ends with an interrupt raise. The raise sets control bit 4 and drives `irq` high only when control bit 5 (interrupt enable) is set. With bit 5 clear, the raise leaves both low.
- R8: A control write that clears a set pending bit also drops `irq`. After that:
  - If the written bit 5 is 0, busy is cleared.
  - Otherwise, if busy is set, the next byte is written in transmit mode (status[7:6] = 3), or read in receive mode.
- R9: A data write is ignored while output enable is clear. In transmit mode with busy set and pending clear, a data write issues a write of that byte at once. With pending set, it only stores the byte.
- R10: A data read in receive mode, with busy set and pending clear, returns the current byte and then issues a read that replaces it.
- R11: Each write and read clears status bit 0 first. A refused write sets bit 0 only when acknowledge generation is set.
- R12: A master-mode status write with bit 5 clear and bit 4 set issues a stop. When the stop completes, busy is cleared unless pending is set.
- R13: A status write in a slave mode (bit 7 = 0) issues no operation.
- R14: `op_req` stays high, with stable operation fields, until `op_ack`. While `op_req` is high, register writes and reads have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Level interrupt |
| op_req | output | 1 | Operation request; also tells software the block is busy |
| op_code | output | 2 | Operation: 0 start, 1 write, 2 read, 3 stop |
| op_addr | output | 7 | Slave address for start |
| op_dir | output | 1 | Direction for start (1 = read) |
| op_wdata | output | 8 | Byte to write |
| op_ack | input | 1 | Operation complete |
| op_rdata | input | 8 | Byte returned by a read |
| op_nack | input | 1 | Slave refused the start or the write |

## Verification
Some properties are checked by assertions on every cycle:
- the request/acknowledge hold rule and the stability of operation fields while a request is open,
- the rule that a control write never sets pending,
- the forced idle after a status write with output enable clear,
- the data register holding while output enable is clear,
- the interrupt rising only together with pending,
- the register freeze while an operation is in flight.

Other behaviour can only be shown by the bench's scenarios:
- the ordering of the chained start-then-read,
- the handling of refusals under each acknowledge-generation setting,
- stop with and without pending,
- receive triggered by a data read,
- the register map itself.

// File: rtl/i2cm_pkg.sv
// Shared encodings for the I2C master register controller.
// Assumes byte-wide registers; bit positions are those software relies on.
package i2cm_pkg;
    localparam int DW = 8;
    localparam int SADDR_W = 7;
    localparam int NREG = 5;
    localparam int STRIDE = 4;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_STOP  = 2'd3
    } op_e;

    // register select indices (offset / STRIDE)
    localparam int SEL_CTRL = 0;
    localparam int SEL_STAT = 1;
    localparam int SEL_ADDR = 2;
    localparam int SEL_DATA = 3;
    localparam int SEL_LINE = 4;

    // control bits
    localparam int CB_ACKGEN = 7;
    localparam int CB_IE     = 5;
    localparam int CB_PEND   = 4;

    // status bits
    localparam int SB_BUSY = 5;
    localparam int SB_OE   = 4;
    localparam int SB_LRB  = 0;

    localparam logic [1:0] MODE_RX = 2'b10;
    localparam logic [1:0] MODE_TX = 2'b11;
endpackage

// File: rtl/i2cm_addr_decode.sv
// Offset decoder: one select line per register at index*STRIDE.
// Assumes exact match; unaligned or out-of-window offsets select nothing.
module i2cm_addr_decode #(
    parameter int ADDR_W = 5,
    parameter int NSEL   = 5,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel
);
    // one comparator per register slot
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i * STEP));
    end
endmodule

// File: rtl/i2cm_op_channel.sv
// Downstream operation channel: latches an operation on launch and holds
// op_req with stable fields until op_ack. A launch in the completing cycle
// chains the next operation without a gap.
module i2cm_op_channel
    import i2cm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  op_e                l_code,
    input  logic [SADDR_W-1:0] l_addr,
    input  logic               l_dir,
    input  logic [DW-1:0]      l_data,
    input  logic               op_ack,
    output logic               op_req,
    output op_e                op_code,
    output logic [SADDR_W-1:0] op_addr,
    output logic               op_dir,
    output logic [DW-1:0]      op_wdata,
    output logic               done
);
    assign done = op_req && op_ack;

    // request register and operation field capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_req   <= 1'b0;
            op_code  <= OP_START;
            op_addr  <= '0;
            op_dir   <= 1'b0;
            op_wdata <= '0;
        end else if (launch) begin
            op_req   <= 1'b1;
            op_code  <= l_code;
            op_addr  <= l_addr;
            op_dir   <= l_dir;
            op_wdata <= l_data;
        end else if (done) begin
            op_req <= 1'b0;
        end
    end

    // R14
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && !op_ack) |=> (op_req && $stable(op_code) && $stable(op_wdata) && $stable(op_addr)));
endmodule

// File: rtl/i2c_host_regs.sv
// I2C master register controller. Register accesses and operation
// completions are resolved in one next-state block; accesses are ignored
// while an operation is outstanding (op_req high). Assumes op_ack is a
// one-cycle pulse given only while op_req is high.
module i2c_host_regs
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              op_req,
    output logic [1:0]        op_code,
    output logic [6:0]        op_addr,
    output logic              op_dir,
    output logic [7:0]        op_wdata,
    input  logic              op_ack,
    input  logic [7:0]        op_rdata,
    input  logic              op_nack
);
    logic [DW-1:0] con, stat, adr, ds, lc;
    logic [DW-1:0] con_n, stat_n, adr_n, ds_n, lc_n;
    logic          irq_q, irq_n;
    logic [NREG-1:0] sel;
    logic          launch, l_dir, done, do_raise;
    op_e           l_code, cur_code;
    logic [SADDR_W-1:0] l_addr;
    logic [DW-1:0] l_data;
    logic          wr_ok, rd_ok, is_rx, is_tx;

    i2cm_addr_decode #(.ADDR_W(ADDR_W), .NSEL(NREG), .STEP(STRIDE)) u_dec (
        .addr(reg_addr), .sel(sel)
    );

    i2cm_op_channel u_chan (
        .clk(clk), .rst_n(rst_n), .launch(launch), .l_code(l_code),
        .l_addr(l_addr), .l_dir(l_dir), .l_data(l_data), .op_ack(op_ack),
        .op_req(op_req), .op_code(cur_code), .op_addr(op_addr),
        .op_dir(op_dir), .op_wdata(op_wdata), .done(done)
    );

    assign op_code = cur_code;
    assign irq     = irq_q;
    assign wr_ok   = reg_wr && !op_req;
    assign rd_ok   = reg_rd && !op_req;
    assign is_rx   = (stat[7:6] == MODE_RX);
    assign is_tx   = (stat[7:6] == MODE_TX);

    // read multiplexer: undecoded offsets return zero
    always_comb begin
        reg_rdata = '0;
        if (sel[SEL_CTRL]) reg_rdata = con;
        if (sel[SEL_STAT]) reg_rdata = stat;
        if (sel[SEL_ADDR]) reg_rdata = adr;
        if (sel[SEL_DATA]) reg_rdata = ds;
        if (sel[SEL_LINE]) reg_rdata = lc;
    end

    // next-state: operation completion first, else a register access
    always_comb begin
        con_n = con; stat_n = stat; adr_n = adr; ds_n = ds; lc_n = lc;
        irq_n = irq_q;
        launch = 1'b0; l_code = OP_START;
        l_addr = ds[7:1]; l_dir = ds[0]; l_data = ds;
        do_raise = 1'b0;
        if (done) begin
            case (cur_code)
                OP_START: begin
                    if (op_nack && con[CB_ACKGEN]) begin
                        stat_n[SB_LRB] = 1'b1;
                        do_raise = 1'b1;
                    end else if (is_rx) begin
                        launch = 1'b1; l_code = OP_READ;
                    end else begin
                        do_raise = 1'b1;
                    end
                end
                OP_WRITE: begin
                    stat_n[SB_LRB] = op_nack && con[CB_ACKGEN];
                    do_raise = 1'b1;
                end
                OP_READ: begin
                    stat_n[SB_LRB] = 1'b0;
                    ds_n = op_rdata;
                    do_raise = 1'b1;
                end
                default: begin
                    if (!con[CB_PEND]) stat_n[SB_BUSY] = 1'b0;
                end
            endcase
        end else if (wr_ok) begin
            if (sel[SEL_CTRL]) begin
                con_n = reg_wdata;
                con_n[CB_PEND] = con[CB_PEND];
                if (con[CB_PEND] && !reg_wdata[CB_PEND]) begin
                    con_n[CB_PEND] = 1'b0;
                    irq_n = 1'b0;
                    if (!reg_wdata[CB_IE]) begin
                        stat_n[SB_BUSY] = 1'b0;
                    end else if (stat[SB_BUSY]) begin
                        if (is_tx) begin
                            launch = 1'b1; l_code = OP_WRITE;
                        end else if (is_rx) begin
                            launch = 1'b1; l_code = OP_READ;
                        end
                    end
                end
            end
            if (sel[SEL_STAT]) begin
                stat_n = reg_wdata;
                stat_n[SB_BUSY] = stat[SB_BUSY];
                if (!reg_wdata[SB_OE]) begin
                    stat_n[SB_BUSY] = 1'b0;
                    irq_n = 1'b0;
                end else if (reg_wdata[7]) begin
                    launch = 1'b1;
                    if (reg_wdata[SB_BUSY]) begin
                        stat_n[SB_LRB] = 1'b0;
                        stat_n[SB_BUSY] = 1'b1;
                        l_code = OP_START;
                    end else begin
                        l_code = OP_STOP;
                    end
                end
            end
            if (sel[SEL_ADDR]) adr_n = reg_wdata;
            if (sel[SEL_LINE]) lc_n = reg_wdata;
            if (sel[SEL_DATA] && stat[SB_OE]) begin
                ds_n = reg_wdata;
                if (is_tx && stat[SB_BUSY] && !con[CB_PEND]) begin
                    launch = 1'b1; l_code = OP_WRITE; l_data = reg_wdata;
                end
            end
        end else if (rd_ok && sel[SEL_DATA] && is_rx && stat[SB_BUSY] && !con[CB_PEND]) begin
            launch = 1'b1; l_code = OP_READ;
        end
        if (do_raise && con_n[CB_IE]) begin
            con_n[CB_PEND] = 1'b1;
            irq_n = 1'b1;
        end
    end

    // register state update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            con <= '0; stat <= '0; adr <= '0; ds <= '0; lc <= '0;
            irq_q <= 1'b0;
        end else begin
            con <= con_n; stat <= stat_n; adr <= adr_n; ds <= ds_n; lc <= lc_n;
            irq_q <= irq_n;
        end
    end

    // R3
    ctl_no_self_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel[SEL_CTRL] && !con[CB_PEND]) |=> !con[CB_PEND]);
    // R4
    oe_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel[SEL_STAT] && !reg_wdata[SB_OE]) |=> (!stat[SB_BUSY] && !irq && !op_req));
    // R7
    irq_with_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> con[CB_PEND]);
    // R9
    ds_hold_oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && sel[SEL_DATA] && !stat[SB_OE]) |=> $stable(ds));
    // R14
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_req && reg_wr && !done) |=> ($stable(adr) && $stable(lc)));
endmodule

// File: tb/i2c_host_regs_bench.sv
module i2c_host_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] A_CTRL = 5'h00, A_STAT = 5'h04, A_ADDR = 5'h08,
                           A_DATA = 5'h0C, A_LINE = 5'h10;
    // {write, offset, value}; for reads value is the expected result
    localparam logic [13:0] TBL [0:8] = '{
        {1'b1, 5'h08, 8'h5D}, {1'b1, 5'h10, 8'hC3}, {1'b1, 5'h14, 8'hFF},
        {1'b1, 5'h0C, 8'h11}, {1'b0, 5'h08, 8'h5D}, {1'b0, 5'h10, 8'hC3},
        {1'b0, 5'h14, 8'h00}, {1'b0, 5'h02, 8'h00}, {1'b0, 5'h0C, 8'h00}
    };

    logic clk = 0, rst_n = 0;
    logic reg_wr = 0, reg_rd = 0;
    logic [4:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic irq, op_req, op_dir, op_ack, op_nack;
    logic [1:0] op_code;
    logic [6:0] op_addr;
    logic [7:0] op_wdata, op_rdata;

    int checks = 0, failures = 0;
    int op_cnt = 0, rsp_lat = 2;
    logic [7:0] rsp_data = 0;
    logic rsp_nack = 0;
    logic [1:0] log_code [0:63];
    logic [6:0] log_addr [0:63];
    logic       log_dir  [0:63];
    logic [7:0] log_data [0:63];

    assign op_rdata = rsp_data;
    assign op_nack  = rsp_nack;

    i2c_host_regs u_i2c_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .op_req(op_req), .op_code(op_code), .op_addr(op_addr),
        .op_dir(op_dir), .op_wdata(op_wdata), .op_ack(op_ack),
        .op_rdata(op_rdata), .op_nack(op_nack)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // downstream responder: logs each operation, acks after rsp_lat cycles
    initial begin
        op_ack = 0;
        forever begin
            @(negedge clk);
            if (rst_n && op_req) begin
                if (op_cnt < 64) begin
                    log_code[op_cnt] = op_code; log_addr[op_cnt] = op_addr;
                    log_dir[op_cnt] = op_dir;   log_data[op_cnt] = op_wdata;
                end
                op_cnt++;
                repeat (rsp_lat - 1) @(negedge clk);
                op_ack = 1;
                @(negedge clk);
                op_ack = 0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        while (op_req) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
        wait_idle();
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 0;
        wait_idle();
    endtask

    task automatic expect_reg(input string req, input logic [4:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(req, v, e);
    endtask

    task automatic expect_ops(input string req, input int base, input int n);
        check(req, op_cnt - base, n);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL R14 watchdog actual=hung expected=complete");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n0;
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq", irq, 0);
        check("R1 op_req", op_req, 0);
        expect_reg("R1 ctrl", A_CTRL, 8'h00);
        expect_reg("R1 stat", A_STAT, 8'h00);
        expect_reg("R1 data", A_DATA, 8'h00);

        // R2 / R9 register map table
        for (int i = 0; i < 9; i++) begin
            if (TBL[i][13]) wr(TBL[i][12:8], TBL[i][7:0]);
            else expect_reg((TBL[i][12:8] == A_DATA) ? "R9 oe-off write" : "R2 map",
                            TBL[i][12:8], TBL[i][7:0]);
        end

        // R3 control write cannot set pending
        wr(A_CTRL, 8'hFF);
        expect_reg("R3 ctrl", A_CTRL, 8'hEF);
        wr(A_CTRL, 8'hA0);

        // R4 output enable off
        n0 = op_cnt;
        wr(A_STAT, 8'hEF);
        expect_reg("R4 stat", A_STAT, 8'hCF);
        expect_ops("R4 no op", n0, 0);
        check("R4 irq", irq, 0);

        // R12 stop while idle, then R5 transmit start
        n0 = op_cnt;
        wr(A_STAT, 8'hD0);
        check("R12 stop code", log_code[n0], 3);
        wr(A_DATA, 8'hA4);
        n0 = op_cnt;
        wr(A_STAT, 8'hF0);
        expect_ops("R5 one op", n0, 1);
        check("R5 start code", log_code[n0], 0);
        check("R5 start addr", log_addr[n0], 7'h52);
        check("R5 start dir", log_dir[n0], 0);
        expect_reg("R5 stat", A_STAT, 8'hF0);
        expect_reg("R7 pend", A_CTRL, 8'hB0);
        check("R7 irq", irq, 1);

        // R9 data write with pending set only stores
        n0 = op_cnt;
        wr(A_DATA, 8'h5A);
        expect_ops("R9 no op", n0, 0);
        expect_reg("R9 stored", A_DATA, 8'h5A);

        // R8 / R11 clear pending -> write, refused with ack generation on
        rsp_nack = 1;
        n0 = op_cnt;
        wr(A_CTRL, 8'hA0);
        check("R8 write code", log_code[n0], 1);
        check("R8 write data", log_data[n0], 8'h5A);
        expect_reg("R11 nack flag", A_STAT, 8'hF1);
        check("R7 irq again", irq, 1);

        // R11 refused write with ack generation off
        wr(A_CTRL, 8'h20);
        expect_reg("R11 no flag", A_STAT, 8'hF0);
        expect_reg("R11 ctrl", A_CTRL, 8'h30);

        // R12 stop with pending keeps busy
        n0 = op_cnt;
        wr(A_STAT, 8'hD0);
        check("R12 stop code", log_code[n0], 3);
        expect_reg("R12 busy kept", A_STAT, 8'hF0);
        // R8 clear pending with interrupts disabled clears busy
        n0 = op_cnt;
        wr(A_CTRL, 8'h00);
        expect_ops("R8 no op", n0, 0);
        expect_reg("R8 busy cleared", A_STAT, 8'hD0);
        check("R8 irq low", irq, 0);

        // R7 interrupts disabled; R9 immediate write
        rsp_nack = 0;
        wr(A_CTRL, 8'h80);
        wr(A_DATA, 8'h31);
        n0 = op_cnt;
        wr(A_STAT, 8'hF0);
        check("R5 addr", log_addr[n0], 7'h18);
        check("R5 dir", log_dir[n0], 1);
        expect_reg("R7 no pend", A_CTRL, 8'h80);
        check("R7 no irq", irq, 0);
        n0 = op_cnt;
        wr(A_DATA, 8'h77);
        expect_ops("R9 one op", n0, 1);
        check("R9 write code", log_code[n0], 1);
        check("R9 write data", log_data[n0], 8'h77);
        wr(A_STAT, 8'hD0);
        expect_reg("R12 busy cleared", A_STAT, 8'hD0);

        // R6 receive start chains a read
        wr(A_CTRL, 8'hA0);
        wr(A_DATA, 8'hA5);
        rsp_data = 8'h3C;
        n0 = op_cnt;
        wr(A_STAT, 8'hB0);
        expect_ops("R6 two ops", n0, 2);
        check("R6 first start", log_code[n0], 0);
        check("R6 then read", log_code[n0+1], 2);
        expect_reg("R6 data", A_DATA, 8'h3C);
        check("R6 irq", irq, 1);
        expect_ops("R10 no read while pend", n0, 2);

        // R8 clear pending in receive -> read
        rsp_data = 8'h9E;
        wr(A_CTRL, 8'hA0);
        expect_reg("R8 read data", A_DATA, 8'h9E);

        // R10 data read triggers receive (interrupts off so pending stays clear)
        wr(A_CTRL, 8'h80);
        rsp_data = 8'h61;
        wr(A_STAT, 8'hB0);
        rsp_data = 8'h42;
        n0 = op_cnt;
        rd(A_DATA, v);
        check("R10 old byte", v, 8'h61);
        expect_ops("R10 one read", n0, 1);
        check("R10 read code", log_code[n0], 2);
        expect_reg("R10 new byte", A_DATA, 8'h42);

        // R6 refused start with ack generation: no read
        wr(A_CTRL, 8'hA0);
        rsp_nack = 1;
        n0 = op_cnt;
        wr(A_STAT, 8'hB0);
        expect_ops("R6 start only", n0, 1);
        expect_reg("R6 nack flag", A_STAT, 8'hB1);
        expect_reg("R6 data kept", A_DATA, 8'h42);

        // R13 slave mode status write
        rsp_nack = 0;
        n0 = op_cnt;
        wr(A_STAT, 8'h30);
        expect_ops("R13 no op", n0, 0);
        expect_reg("R13 stat", A_STAT, 8'h30);

        // R14 writes ignored while an operation is open
        rsp_lat = 6;
        wr(A_CTRL, 8'h80);
        @(negedge clk);
        reg_wr = 1; reg_addr = A_STAT; reg_wdata = 8'hB0;
        @(negedge clk);
        reg_addr = A_ADDR; reg_wdata = 8'h99;
        check("R14 req open", op_req, 1);
        @(negedge clk);
        reg_wr = 0;
        wait_idle();
        rsp_lat = 2;
        expect_reg("R14 addr kept", A_ADDR, 8'h5D);

        // R1 reset again
        @(negedge clk);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        check("R1 irq after", irq, 0);
        expect_reg("R1 ctrl after", A_CTRL, 8'h00);
        expect_reg("R1 addr after", A_ADDR, 8'h00);
        expect_reg("R1 line after", A_LINE, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule